// File: doc/BRIEF.md
# Ratioed Clock Sync-Pulse Generator

This block sits in the fast clock domain beside a crossing between a fast clock and a slow clock. The two clocks come from the same reference and run at a fixed rational ratio. The block emits a one-fast-cycle enable pulse once per slow clock cycle. Data moves across the crossing only on that pulse. One pulse stream serves transfers in both directions, so only one signal needs to be distributed.

The ratio is selected in quarter steps between 2.00 and 5.25, so the pattern always repeats over four slow cycles, which is `N` fast cycles for a ratio of `N/4`. An alignment marker marks the fast edge that coincides with a slow rising edge. That edge is fast cycle 0 of the pattern. Inside each slow cycle the pulse lands on the fast edge nearest that slow cycle's midpoint, and an exact tie goes to the earlier edge. The pattern is computed from the ratio rather than stored, and every marker restarts it. Without a marker the pattern wraps on its own every `N` fast cycles. The marker is also echoed, one cycle later, as a synchronous reset for the fractional divider that makes the derived clocks.

A two-state controller governs the block:
- `ST_IDLE` is the state after reset. No pulses are issued and the block waits for the first marker.
- Transition `T_START`: a marker sampled in `ST_IDLE` moves the controller to `ST_RUN`.
- `ST_RUN` steps the pattern. In `ST_RUN` the only transition is `T_HOLD`, which returns to `ST_RUN` on every cycle whether or not a marker arrives.

Top module: `sps_sync_pulse_gen`

## Requirements
- R1: After reset, and until the first marker is sampled, `sync_pulse_o` and `div_reset_o` are low.
- R2: `ratio_sel` gives the ratio in quarters, so the ratio is `N/4` with `N = ratio_sel`. Values below 8 are treated as 8 (2.00), and values above 21 are treated as 21 (5.25).
- R3: Let the marker be sampled at fast edge E0. For each slow slot k = 0..3, the pulse appears at edge E0+o_k and is visible until the next edge. Here o_k is the integer t closest to the slot midpoint (2k+1)·N/8, with an exact tie going to the smaller t. For example, N=11 gives offsets 1, 4, 7, 10 and N=20 gives offsets 2, 7, 12, 17.
- R4: Each pulse is high for exactly one fast cycle. Across the N edges that follow a marker, exactly four pulses occur.
- R5: If no further marker arrives, the pattern repeats with a period of N fast cycles, and the phase never reaches N.
- R6: A marker sampled at any point in the pattern restarts it, so the offsets of R3 count from that marker. No pulse occurs at the edge that samples a marker.
- R7: A change of `ratio_sel` has no effect until the next marker is sampled. The ratio is captured at the marker edge.
- R8: `div_reset_o` is high for exactly the one fast cycle after each edge at which the marker is sampled, and it is low otherwise. This holds in both states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 5 | Fast:slow ratio in quarter units |
| aligned_i | input | 1 | Coincident-edge marker, sampled on the fast clock |
| sync_pulse_o | output | 1 | Transfer enable for both directions, one fast cycle wide |
| div_reset_o | output | 1 | Synchronous reset for the fractional divider |

## Verification
Both outputs come from a single register stage. A marker sampled at edge E0 shows on `div_reset_o` from E0 until E0+1, and the pulse for slot k shows from edge E0+o_k. The bench drives inputs on the falling edge. After each rising edge it advances its own phase model, then compares both outputs at the following falling edge against the nearest-midpoint rule, which it evaluates as a distance window rather than as an offset formula. Directed runs record the phases at which pulses occur over one whole period, compare them with hand-derived offset masks for exact ratios, ties and clamped selects, and count four pulses per period. Random segments then mix regular and irregular marker spacing with random ratio changes.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sps_state_e;

endpackage

// File: rtl/sps_ratio_latch.sv
module sps_ratio_latch #(
    parameter int NMIN = 8,
    parameter int NMAX = 21,
    parameter int QW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [QW-1:0] sel_i,
    output logic [QW-1:0] ratio_o
);

    localparam logic [QW-1:0] LO = QW'(NMIN);
    localparam logic [QW-1:0] HI = QW'(NMAX);

    logic [QW-1:0] sel_clamped;
    logic [QW-1:0] ratio_q;

    always_comb begin
        if (sel_i < LO) begin
            sel_clamped = LO;
        end else if (sel_i > HI) begin
            sel_clamped = HI;
        end else begin
            sel_clamped = sel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= LO;
        end else if (load_i) begin
            ratio_q <= sel_clamped;
        end
    end

    assign ratio_o = ratio_q;

    // R7
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(ratio_q));

    // R2
    ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_q >= LO) && (ratio_q <= HI));

    // R2
    ratio_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel_i >= LO && sel_i <= HI) |=> (ratio_q == $past(sel_i)));

endmodule

// File: rtl/sps_phase_ctr.sv
module sps_phase_ctr #(
    parameter int QW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          restart_i,
    input  logic [QW-1:0] ratio_i,
    output logic [QW-1:0] phase_nxt_o
);

    logic [QW-1:0] phase_q;
    logic [QW-1:0] phase_d;
    logic          at_end;

    assign at_end = (phase_q == (ratio_i - QW'(1)));

    always_comb begin
        if (restart_i) begin
            phase_d = '0;
        end else if (run_i) begin
            phase_d = at_end ? '0 : (phase_q + QW'(1));
        end else begin
            phase_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_nxt_o = phase_d;

    // R5
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < ratio_i);

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (phase_q == '0));

endmodule

// File: rtl/sps_slot_match.sv
module sps_slot_match #(
    parameter int RES = 4,
    parameter int QW  = 5
) (
    input  logic [QW-1:0] ratio_i,
    input  logic [QW-1:0] phase_i,
    output logic          hit_o
);

    localparam int PW = QW + $clog2(2 * RES) + 1;

    logic [RES-1:0] hit_vec;

    for (genvar k = 0; k < RES; k++) begin : g_slot
        logic [PW-1:0] num;
        logic [PW-1:0] off;
        // nearest fast edge to the slot midpoint, ties to the earlier edge
        assign num = (PW'(2 * k + 1) * PW'(ratio_i)) + PW'(RES - 1);
        assign off = num / PW'(2 * RES);
        assign hit_vec[k] = (off == PW'(phase_i));
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/sps_sync_pulse_gen.sv
module sps_sync_pulse_gen
    import sps_pkg::*;
#(
    parameter int RES  = 4,
    parameter int NMIN = 8,
    parameter int NMAX = 21,
    parameter int QW   = $clog2(NMAX + 1)
) (
    input  logic          clk_fast,
    input  logic          rst_n,
    input  logic [QW-1:0] ratio_sel,
    input  logic          aligned_i,
    output logic          sync_pulse_o,
    output logic          div_reset_o
);

    sps_state_e    state_q;
    sps_state_e    state_d;
    logic [QW-1:0] ratio_q;
    logic [QW-1:0] phase_nxt;
    logic          slot_hit;
    logic          run;
    logic          pulse_q;
    logic          divrst_q;

    assign run = (state_q == ST_RUN);

    sps_ratio_latch #(
        .NMIN (NMIN),
        .NMAX (NMAX),
        .QW   (QW)
    ) u_ratio (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .load_i  (aligned_i),
        .sel_i   (ratio_sel),
        .ratio_o (ratio_q)
    );

    sps_phase_ctr #(
        .QW (QW)
    ) u_phase (
        .clk         (clk_fast),
        .rst_n       (rst_n),
        .run_i       (run),
        .restart_i   (aligned_i),
        .ratio_i     (ratio_q),
        .phase_nxt_o (phase_nxt)
    );

    sps_slot_match #(
        .RES (RES),
        .QW  (QW)
    ) u_match (
        .ratio_i (ratio_q),
        .phase_i (phase_nxt),
        .hit_o   (slot_hit)
    );

    // next state: T_START leaves idle on a marker, T_HOLD keeps running
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (aligned_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            pulse_q  <= 1'b0;
            divrst_q <= 1'b0;
        end else begin
            divrst_q <= aligned_i;
            unique case (state_q)
                ST_IDLE: pulse_q <= 1'b0;
                ST_RUN:  pulse_q <= slot_hit;
                default: pulse_q <= 1'b0;
            endcase
        end
    end

    assign sync_pulse_o = pulse_q;
    assign div_reset_o  = divrst_q;

    // R4
    pulse_one_cycle_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        sync_pulse_o |=> !sync_pulse_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !sync_pulse_o);

    // R6
    restart_gap_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        aligned_i |=> !sync_pulse_o);

    // R8
    div_reset_on_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        aligned_i |=> div_reset_o);

    // R8
    div_reset_off_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !aligned_i |=> !div_reset_o);

endmodule

// File: tb/sps_sync_pulse_gen_tb.sv
`timescale 1ns/1ps
module sps_sync_pulse_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ratio_sel = 5'd11;
    logic       aligned = 1'b0;
    logic       sync_pulse_o;
    logic       div_reset_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_run = 0;
    int m_n = 8;
    int m_ph = 0;
    int pulse_cnt = 0;
    logic [31:0] mask = '0;

    always #2 clk = ~clk;

    sps_sync_pulse_gen u_dut (
        .clk_fast     (clk),
        .rst_n        (rst_n),
        .ratio_sel    (ratio_sel),
        .aligned_i    (aligned),
        .sync_pulse_o (sync_pulse_o),
        .div_reset_o  (div_reset_o)
    );

    function automatic int clampf(input int s);
        if (s < 8) return 8;
        if (s > 21) return 21;
        return s;
    endfunction

    // R3 distance rule: t is chosen when 8t - 8*mid lies in [-4, 4)
    function automatic bit pulse_fn(input int n, input int t);
        for (int k = 0; k < 4; k++) begin
            int d;
            d = 8 * t - (2 * k + 1) * n;
            if (d >= -4 && d < 4) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic step(input logic mk, input logic [4:0] sel);
        int exp_p;
        aligned = mk;
        ratio_sel = sel;
        @(posedge clk);
        if (mk) begin
            m_run = 1;
            m_n = clampf(int'(sel));
            m_ph = 0;
        end else if (m_run != 0) begin
            m_ph = (m_ph + 1 == m_n) ? 0 : m_ph + 1;
        end
        @(negedge clk);
        exp_p = (m_run != 0 && pulse_fn(m_n, m_ph)) ? 1 : 0;
        if (m_run == 0) check("R1 pulse idle", int'(sync_pulse_o), 0);
        else check("R3 pulse placement", int'(sync_pulse_o), exp_p);
        check("R8 div reset", int'(div_reset_o), int'(mk));
        if (sync_pulse_o) begin
            pulse_cnt++;
            mask[m_ph] = 1'b1;
        end
    endtask

    // marker then N-1 plain steps, mask and count over one period
    task automatic period(input logic [4:0] sel, input logic [31:0] exp_mask, input string tag);
        int n;
        n = clampf(int'(sel));
        mask = '0;
        pulse_cnt = 0;
        step(1'b1, sel);
        for (int i = 1; i < n; i++) step(1'b0, sel);
        check(tag, int'(mask), int'(exp_mask));
        step(1'b0, sel);
        check("R4 four pulses per period", pulse_cnt, 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        check("R1 reset pulse", int'(sync_pulse_o), 0);
        check("R1 reset divrst", int'(div_reset_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) step(1'b0, 5'd11);

        // R3 exact ratio 2.75: offsets 1,4,7,10
        period(5'd11, 32'h0000_0492, "R3 mask N=11");
        // R3 ties to earlier edge: N=12 -> 1,4,7,10 ; N=20 -> 2,7,12,17
        period(5'd12, 32'h0000_0492, "R3 tie mask N=12");
        period(5'd20, 32'h0002_1084, "R3 tie mask N=20");
        // N=21 -> 3,8,13,18 ; N=8 -> 1,3,5,7
        period(5'd21, 32'h0004_2108, "R3 mask N=21");
        period(5'd8,  32'h0000_00AA, "R3 mask N=8");
        // R2 clamping
        period(5'd3,  32'h0000_00AA, "R2 clamp low");
        period(5'd31, 32'h0004_2108, "R2 clamp high");

        // R5 free run: N=11 without marker, mask over next period
        period(5'd11, 32'h0000_0492, "R3 mask N=11 again");
        mask = '0;
        pulse_cnt = 0;
        for (int i = 1; i < 11; i++) step(1'b0, 5'd11);
        check("R5 free run mask", int'(mask), 32'h0000_0492);
        check("R5 free run count", pulse_cnt, 4);
        step(1'b0, 5'd11);

        // R7 ratio change ignored until marker
        period(5'd8, 32'h0000_00AA, "R3 mask N=8 pre");
        mask = '0;
        for (int i = 1; i < 8; i++) step(1'b0, 5'd20);
        check("R7 ratio change deferred", int'(mask), 32'h0000_00AA);
        step(1'b0, 5'd20);
        period(5'd20, 32'h0002_1084, "R7 ratio applied at marker");

        // R6 restart mid pattern
        step(1'b1, 5'd11);
        for (int i = 0; i < 5; i++) step(1'b0, 5'd11);
        period(5'd11, 32'h0000_0492, "R6 restart mask");

        // random segments
        for (int s = 0; s < 400; s++) begin
            logic [4:0] sel;
            int len;
            sel = 5'($urandom % 32);
            len = (($urandom % 2) == 0) ? clampf(int'(sel)) : int'($urandom % 40) + 1;
            step(1'b1, sel);
            for (int i = 1; i < len; i++) step(1'b0, 5'($urandom % 32));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule